// File: doc/BRIEF.md
# Fail-Safe Clock Monitor with Switchover

This block watches an external primary clock from the domain of an internal reference oscillator that never stops. The reference is divided down into a slow sample clock. A monitor latch is armed on each rising phase of the sample clock and cleared by any falling edge of the primary clock. If the latch is still armed when the sample clock falls, the primary clock is declared dead.

After reset the system runs from the internal source. The block waits for the start-up timer to report that the primary oscillator is ready, and then selects the primary clock and sets a primary-running status bit. When a failure is detected, the block does four things: it sets a sticky interrupt flag, moves the clock select back to the internal source, emits a one-cycle restart for the watchdog counter and its postscaler, and raises a fail-safe indicator.

The primary-running status is deliberately left unchanged while the block is in the fail-safe state. The fail-safe state can be left only through reset or through entry into a power-managed mode. The glitch-free multiplexer, the start-up timer and the watchdog live outside this block.

Top module: `clk_failsafe_monitor`

## Requirements
- R1: While reset is asserted, and after its release, the outputs are: clock select = internal (`sel_internal`=1), `pri_running`=0, `failsafe`=0, `osc_fail_flag`=0 and `wdt_restart`=0.
- R2: After reset the select stays internal for as long as `pri_ready` is 0, even if the primary clock toggles. In the first reference cycle after a rising clock edge that samples `pri_ready`=1, `sel_internal` is 0 and `pri_running` is 1.
- R3: While the primary clock produces at least one falling edge in every half sample period, no failure is reported. A sample period is 64 reference cycles.
- R4: If the primary clock stops while the block is running from it with `mon_en`=1, the block must react within 2*64+SYNC_STAGES+4 reference cycles. It sets `failsafe`=1, `sel_internal`=1 and `osc_fail_flag`=1.
- R5: On entry into the fail-safe state, `wdt_restart` is high for exactly one reference cycle. That cycle is the first cycle in which `failsafe` reads 1.
- R6: In the fail-safe state, `pri_running` keeps the value 1 that it had before the failure.
- R7: The fail-safe state persists while `pm_enter` is 0. It persists even if the primary clock restarts and `pri_ready` is 1.
- R8: A one-cycle `pm_enter` pulse in the fail-safe state has this effect in the next cycle: `failsafe`=0, `sel_internal`=1 and `pri_running`=0. The block then waits for `pri_ready` again, as in R2.
- R9: `osc_fail_flag` stays set until a `flag_clr` pulse. The flag reads 0 in the cycle after that pulse. Leaving the fail-safe state does not clear it.
- R10: With `mon_en`=0, a stopped primary clock causes no failure, no flag and no restart pulse.
- R11: A `pm_enter` pulse outside the fail-safe state has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Internal reference oscillator; all control logic runs on it |
| rst_n | input | 1 | Asynchronous active-low device reset |
| pri_clk | input | 1 | Monitored primary clock |
| mon_en | input | 1 | Monitor enable configuration bit |
| pri_ready | input | 1 | Start-up timer reports primary oscillator stable |
| pm_enter | input | 1 | One-cycle strobe: power-managed mode entered |
| flag_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| sel_internal | output | 1 | Clock select: 1 = internal source, 0 = primary |
| osc_fail_flag | output | 1 | Sticky oscillator-fail interrupt flag |
| wdt_restart | output | 1 | One-cycle restart request for watchdog and postscaler |
| failsafe | output | 1 | Fail-safe state indicator |
| pri_running | output | 1 | Clock-source status: primary selected |

## Verification
The assertions assume three things about the inputs. First, `pm_enter` and `flag_clr` are single-cycle strobes that are synchronous to the reference clock. Second, `pri_ready` changes only on the reference clock. Third, a running primary clock toggles slowly enough that the synchronizer sees every toggle. The bench drives all strobes and levels on the falling edge of the reference clock. It picks primary half-periods between 14 and 31 ns against a 10 ns reference. This gives several primary edges in every 320 ns half sample period while keeping each toggle longer than one reference cycle.

// File: rtl/fscm_pkg.sv
package fscm_pkg;

  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_RUN  = 2'd1,
    ST_SAFE = 2'd2
  } fscm_state_e;

  // Sample-clock period in reference cycles.
  function automatic int unsigned sample_period(input int unsigned div_log2);
    return 32'd1 << div_log2;
  endfunction

  // Worst-case reference cycles from last primary edge to fail-safe entry.
  function automatic int unsigned detect_bound(input int unsigned div_log2,
                                               input int unsigned sync_stages);
    return 2 * sample_period(div_log2) + sync_stages + 4;
  endfunction

endpackage

// File: rtl/fscm_edge_sync.sv
module fscm_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic pri_clk,
  input  logic ref_clk,
  input  logic rst_n,
  output logic pri_edge
);
  logic               tog_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic               last_q;

  // Toggle on every falling edge of the monitored clock.
  always_ff @(negedge pri_clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= ~tog_q;
  end

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= tog_q;
      end
    end else begin : g_next
      always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[SYNC_STAGES-1];
  end

  assign pri_edge = sync_q[SYNC_STAGES-1] ^ last_q;

endmodule

// File: rtl/fscm_sample_div.sv
module fscm_sample_div #(
  parameter int DIV_LOG2 = 6
) (
  input  logic ref_clk,
  input  logic rst_n,
  output logic smp_rise,
  output logic smp_fall
);
  localparam logic [DIV_LOG2-1:0] PH_RISE = '0;
  localparam logic [DIV_LOG2-1:0] PH_FALL = {1'b1, {(DIV_LOG2-1){1'b0}}};

  logic [DIV_LOG2-1:0] cnt_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign smp_rise = (cnt_q == PH_RISE);
  assign smp_fall = (cnt_q == PH_FALL);

  // A falling phase is followed by a rising phase exactly half a period later.
  a_r4_fall_then_rise_spacing: assert property (@(posedge ref_clk) disable iff (!rst_n)
    smp_fall |=> !smp_rise && !smp_fall);

endmodule

// File: rtl/fscm_mon_latch.sv
module fscm_mon_latch (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic active,
  input  logic smp_rise,
  input  logic smp_fall,
  input  logic pri_edge,
  output logic fail_evt
);
  logic armed_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)         armed_q <= 1'b0;
    else if (!active)   armed_q <= 1'b0;
    else if (smp_rise)  armed_q <= 1'b1;
    else if (pri_edge)  armed_q <= 1'b0;
  end

  assign fail_evt = active && smp_fall && armed_q && !pri_edge;

  // R3: an observed edge always clears the latch before the next check.
  a_r3_edge_disarms: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pri_edge && !smp_rise |=> !armed_q);

  // R10: an inactive monitor leaves nothing armed.
  a_r10_idle_disarmed: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !active |=> !armed_q);

endmodule

// File: rtl/fscm_ctrl.sv
module fscm_ctrl
  import fscm_pkg::*;
(
  input  logic ref_clk,
  input  logic rst_n,
  input  logic fail_evt,
  input  logic pri_ready,
  input  logic pm_enter,
  input  logic flag_clr,
  output logic monitoring,
  output logic sel_internal,
  output logic osc_fail_flag,
  output logic wdt_restart,
  output logic failsafe,
  output logic pri_running
);
  fscm_state_e state_q, state_d;
  logic        running_q, running_d;
  logic        flag_q, wdt_q;

  always_comb begin
    state_d   = state_q;
    running_d = running_q;
    unique case (state_q)
      ST_BOOT: if (pri_ready) begin
        state_d   = ST_RUN;
        running_d = 1'b1;
      end
      ST_RUN:  if (fail_evt) state_d = ST_SAFE;
      ST_SAFE: if (pm_enter) begin
        state_d   = ST_BOOT;
        running_d = 1'b0;
      end
      default: begin
        state_d   = ST_BOOT;
        running_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_BOOT;
      running_q <= 1'b0;
      flag_q    <= 1'b0;
      wdt_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      running_q <= running_d;
      wdt_q     <= (state_q == ST_RUN) && fail_evt;
      if ((state_q == ST_RUN) && fail_evt) flag_q <= 1'b1;
      else if (flag_clr)                   flag_q <= 1'b0;
    end
  end

  assign monitoring    = (state_q == ST_RUN);
  assign sel_internal  = (state_q != ST_RUN);
  assign failsafe      = (state_q == ST_SAFE);
  assign pri_running   = running_q;
  assign osc_fail_flag = flag_q;
  assign wdt_restart   = wdt_q;

  a_r5_restart_single: assert property (@(posedge ref_clk) disable iff (!rst_n)
    wdt_restart |=> !wdt_restart);
  a_r5_restart_on_entry: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(failsafe) |-> wdt_restart);
  a_r6_status_kept: assert property (@(posedge ref_clk) disable iff (!rst_n)
    failsafe |-> pri_running);
  a_r7_safe_sticky: assert property (@(posedge ref_clk) disable iff (!rst_n)
    failsafe && !pm_enter |=> failsafe && sel_internal);
  a_r8_pm_exit: assert property (@(posedge ref_clk) disable iff (!rst_n)
    failsafe && pm_enter |=> !failsafe && sel_internal && !pri_running);
  a_r9_flag_clear_only: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(osc_fail_flag) |-> $past(flag_clr));
  a_r4_fail_from_run: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(failsafe) |-> $past(monitoring));

endmodule

// File: rtl/clk_failsafe_monitor.sv
module clk_failsafe_monitor #(
  parameter int DIV_LOG2    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic pri_clk,
  input  logic mon_en,
  input  logic pri_ready,
  input  logic pm_enter,
  input  logic flag_clr,
  output logic sel_internal,
  output logic osc_fail_flag,
  output logic wdt_restart,
  output logic failsafe,
  output logic pri_running
);
  logic pri_edge;
  logic smp_rise, smp_fall;
  logic fail_evt;
  logic monitoring;
  logic mon_active;

  assign mon_active = monitoring && mon_en;

  fscm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .pri_clk (pri_clk),
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .pri_edge(pri_edge)
  );

  fscm_sample_div #(.DIV_LOG2(DIV_LOG2)) u_div (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .smp_rise(smp_rise),
    .smp_fall(smp_fall)
  );

  fscm_mon_latch u_latch (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .active  (mon_active),
    .smp_rise(smp_rise),
    .smp_fall(smp_fall),
    .pri_edge(pri_edge),
    .fail_evt(fail_evt)
  );

  fscm_ctrl u_ctrl (
    .ref_clk      (ref_clk),
    .rst_n        (rst_n),
    .fail_evt     (fail_evt),
    .pri_ready    (pri_ready),
    .pm_enter     (pm_enter),
    .flag_clr     (flag_clr),
    .monitoring   (monitoring),
    .sel_internal (sel_internal),
    .osc_fail_flag(osc_fail_flag),
    .wdt_restart  (wdt_restart),
    .failsafe     (failsafe),
    .pri_running  (pri_running)
  );

  a_r10_disabled_quiet: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !mon_en && !failsafe |=> !$rose(failsafe));
  a_r1_select_consistent: assert property (@(posedge ref_clk) disable iff (!rst_n)
    failsafe |-> sel_internal);

endmodule

// File: tb/clk_failsafe_monitor_bench.sv
module clk_failsafe_monitor_bench;
  localparam int REF_PERIOD  = 10;
  localparam int DIV_LOG2    = 6;
  localparam int SYNC_STAGES = 2;

  logic ref_clk = 1'b0;
  logic pri_clk = 1'b0;
  logic rst_n = 1'b0;
  logic mon_en = 1'b1, pri_ready = 1'b0, pm_enter = 1'b0, flag_clr = 1'b0;
  logic sel_internal, osc_fail_flag, wdt_restart, failsafe, pri_running;
  logic pri_on = 1'b1;
  int   pri_half = 17;
  int   tests = 0, fails = 0, cycles = 0;

  clk_failsafe_monitor #(.DIV_LOG2(DIV_LOG2), .SYNC_STAGES(SYNC_STAGES)) u_clk_failsafe_monitor (
    .ref_clk(ref_clk), .rst_n(rst_n), .pri_clk(pri_clk), .mon_en(mon_en),
    .pri_ready(pri_ready), .pm_enter(pm_enter), .flag_clr(flag_clr),
    .sel_internal(sel_internal), .osc_fail_flag(osc_fail_flag),
    .wdt_restart(wdt_restart), .failsafe(failsafe), .pri_running(pri_running)
  );

  always #(REF_PERIOD/2) ref_clk = ~ref_clk;
  always begin
    #(pri_half);
    if (pri_on) pri_clk = ~pri_clk;
  end

  function automatic int bound_cycles();
    return 2 * (1 << DIV_LOG2) + SYNC_STAGES + 4;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge ref_clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic pulse_pm();
    pm_enter = 1'b1; @(negedge ref_clk); pm_enter = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; @(negedge ref_clk); flag_clr = 1'b0;
  endtask

  // Stop the primary clock and watch for fail-safe entry.
  task automatic stop_and_detect(input string req);
    int n = 0;
    bit seen = 0;
    pri_on = 1'b0;
    for (int i = 0; i < bound_cycles() + 20 && !seen; i++) begin
      @(negedge ref_clk);
      n++;
      if (failsafe) begin
        seen = 1;
        check("R5", {31'd0, wdt_restart}, 32'd1);
        check("R4", {29'd0, sel_internal, osc_fail_flag, pri_running}, 32'd7);
      end
    end
    check(req, {31'd0, seen}, 32'd1);
    check("R4", {31'd0, (n <= bound_cycles())}, 32'd1);
    @(negedge ref_clk);
    check("R5", {31'd0, wdt_restart}, 32'd0);
  endtask

  // Bring the block back to running from the primary clock.
  task automatic restore();
    pri_on = 1'b1;
    pri_ready = 1'b0;
    wait_cyc(3);
    if (failsafe) pulse_pm();
    wait_cyc(2);
    pri_ready = 1'b1;
    @(negedge ref_clk);
    check("R2", {30'd0, sel_internal, pri_running}, 32'd1);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    wait_cyc(3);
    check("R1", {27'd0, sel_internal, pri_running, failsafe, osc_fail_flag, wdt_restart}, 32'h10);
    rst_n = 1'b1;
    wait_cyc(200);
    check("R1", {27'd0, sel_internal, pri_running, failsafe, osc_fail_flag, wdt_restart}, 32'h10);
    check("R2", {31'd0, sel_internal}, 32'd1);
    pri_ready = 1'b1;
    @(negedge ref_clk);
    check("R2", {30'd0, sel_internal, pri_running}, 32'd1);

    wait_cyc(500);
    check("R3", {30'd0, failsafe, osc_fail_flag}, 32'd0);

    pulse_pm();
    check("R11", {29'd0, sel_internal, pri_running, failsafe}, 32'd2);

    stop_and_detect("R4");
    check("R6", {31'd0, pri_running}, 32'd1);

    pri_on = 1'b1;
    wait_cyc(300);
    check("R7", {30'd0, failsafe, sel_internal}, 32'd3);

    pulse_clr();
    check("R9", {31'd0, osc_fail_flag}, 32'd0);

    pri_ready = 1'b0;
    pulse_pm();
    check("R8", {29'd0, failsafe, sel_internal, pri_running}, 32'd2);
    wait_cyc(20);
    check("R8", {31'd0, sel_internal}, 32'd1);
    pri_ready = 1'b1;
    @(negedge ref_clk);
    check("R8", {30'd0, sel_internal, pri_running}, 32'd1);

    stop_and_detect("R4");
    pri_ready = 1'b0;
    pulse_pm();
    check("R9", {31'd0, osc_fail_flag}, 32'd1);
    pulse_clr();
    restore();

    mon_en = 1'b0;
    pri_on = 1'b0;
    wait_cyc(4 * (1 << DIV_LOG2));
    check("R10", {29'd0, failsafe, osc_fail_flag, wdt_restart}, 32'd0);
    pri_on = 1'b1;
    wait_cyc(5);
    mon_en = 1'b1;

    for (int t = 0; t < 14; t++) begin
      int kind;
      case ($urandom_range(0, 3))
        0: pri_half = 14;
        1: pri_half = 17;
        2: pri_half = 23;
        default: pri_half = 31;
      endcase
      kind = int'($urandom_range(0, 2));
      if (kind == 0) begin
        wait_cyc(int'($urandom_range(200, 700)));
        check("R3", {30'd0, failsafe, sel_internal}, 32'd0);
      end else if (kind == 1) begin
        stop_and_detect("R4");
        pulse_clr();
        check("R9", {31'd0, osc_fail_flag}, 32'd0);
        restore();
      end else begin
        mon_en = 1'b0;
        pri_on = 1'b0;
        wait_cyc(int'($urandom_range(150, 400)));
        check("R10", {30'd0, failsafe, osc_fail_flag}, 32'd0);
        pri_on = 1'b1;
        wait_cyc(5);
        mon_en = 1'b1;
      end
    end

    finish_run();
  end

endmodule